// File: doc/BRIEF.md
# Partial-Decode I/O Port Selector

This block sits between a simple processor's I/O bus and a small register-test fixture. It watches a 16-bit address, a memory/IO select and active-low read and write strobes, and turns qualified I/O cycles into active-low port selects. There are five selects: a result-buffer read enable, a reset strobe and a clock strobe for the register under test, a stimulus-latch load and a mode-latch load. On a qualified read of the result port, it gates the fixture's result byte onto the low data byte and raises an output enable. At all other times that byte is held at zero.

The decoding is deliberately partial. An access qualifies only if it is an I/O cycle (memory/IO select low), address bit 15 is low, and address bit 0 is low. Address bits 4..1 then pick one of sixteen even port numbers (port = 2 × bits[4:1]). Bits 14..5 are never examined, so every port has many aliases. The stimulus latch (8 bits) and the mode latch (2 bits) are built as clocked registers. They load on every clock edge during which their write strobe is active, so they keep the last stable byte the processor presented.

Top module: `ioPortDecoder`

## Requirements
- R1: When memIoN is 1 (memory cycle), every select output stays 1 and no latch changes, whatever the address and strobes.
- R2: When addr[15] is 1, no select is asserted.
- R3: When addr[0] is 1, no select is asserted.
- R4: Address bits 14..5 are ignored, so an address decodes to the same port as its copy with those bits cleared.
- R5: A qualified read of port 0 (addr[4:1]=0, rdN=0) drives resultRdN=0 and dataOutEn=1, and sets dataOut equal to resultIn.
- R6: A qualified write of port 0 drives stimLoadN=0, and stimVec takes dataIn at each rising clock edge while it is low. stimVec holds its value otherwise.
- R7: A qualified write of port 2 drives regResetN=0, and one of port 4 drives regClockN=0. Each of these is asserted only while wrN is 0.
- R8: A qualified write of port 6 drives modeLoadN=0, and modeBits takes dataIn[1:0] at each rising clock edge while it is low.
- R9: Whenever there is no qualified read of port 0, dataOutEn is 0 and dataOut is 0.
- R10: An active-low rstN clears stimVec and modeBits to 0.
- R11: At most one of the four write selects (stimLoadN, regResetN, regClockN, modeLoadN) is low at any time.
- R12: Ports 2, 4 and 6 respond only to writes, and any even port other than 0, 2, 4 and 6 produces no select. Accesses that produce no select leave the latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stimulus and mode latches |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| memIoN | input | 1 | Memory/IO select, low for an I/O cycle |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| dataIn | input | 8 | Write data from the processor, low byte |
| resultIn | input | 8 | Result byte from the register under test |
| dataOut | output | 8 | Read data to the processor, zero unless enabled |
| dataOutEn | output | 1 | High while dataOut drives the bus |
| resultRdN | output | 1 | Active-low result-buffer read enable |
| stimLoadN | output | 1 | Active-low stimulus-latch load |
| regResetN | output | 1 | Active-low reset strobe for the register under test |
| regClockN | output | 1 | Active-low clock strobe for the register under test |
| modeLoadN | output | 1 | Active-low mode-latch load |
| stimVec | output | 8 | Stimulus latch contents |
| modeBits | output | 2 | Mode latch contents |

## Verification
The bench aims at the qualification edges: a memory cycle, address bit 15 set, and an odd address. A decoder that dropped any of these terms would fire a port select during an access it must ignore. It probes aliases with upper bits set, which a design decoding too many lines would miss. It also probes reads of write-only ports and writes to unused even ports, which a design with a loose read/write term would turn into spurious strobes or latch loads. Latch contents are read back after writes to other ports and after memory cycles, to expose a load enable that leaks.

// File: rtl/ioPortDecoderPkg.sv
package ioPortDecoderPkg;
  // Active-high strobes passed from control to datapath
  typedef struct packed {
    logic rdResult;
    logic wrStim;
    logic wrReset;
    logic wrClock;
    logic wrMode;
  } portStrobeT;
endpackage

// File: rtl/ioDecodeCtrl.sv
module ioDecodeCtrl
  import ioPortDecoderPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SEL_LO     = 1,
  parameter int SEL_W      = 4,
  parameter int RESULT_PORT = 0,
  parameter int RESET_PORT  = 2,
  parameter int CLOCK_PORT  = 4,
  parameter int MODE_PORT   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              memIoN,
  input  logic              rdN,
  input  logic              wrN,
  output portStrobeT        strobe
);
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int RES_IDX = RESULT_PORT >> SEL_LO;
  localparam int RST_IDX = RESET_PORT  >> SEL_LO;
  localparam int CLK_IDX = CLOCK_PORT  >> SEL_LO;
  localparam int MOD_IDX = MODE_PORT   >> SEL_LO;

  logic               ioCycle;
  logic [SEL_W-1:0]   selField;
  logic [NUM_SEL-1:0] decOutN;

  assign ioCycle  = !memIoN && !addr[ADDR_W-1] && !addr[0];
  assign selField = addr[SEL_LO +: SEL_W];

  // 1-of-N decode with active-low outputs
  genvar i;
  generate
    for (i = 0; i < NUM_SEL; i++) begin : gDec
      assign decOutN[i] = !(ioCycle && (selField == SEL_W'(i)));
    end
  endgenerate

  always_comb begin
    strobe.rdResult = !decOutN[RES_IDX] && !rdN;
    strobe.wrStim   = !decOutN[RES_IDX] && !wrN;
    strobe.wrReset  = !decOutN[RST_IDX] && !wrN;
    strobe.wrClock  = !decOutN[CLK_IDX] && !wrN;
    strobe.wrMode   = !decOutN[MOD_IDX] && !wrN;
  end
endmodule

// File: rtl/ioDecodeData.sv
module ioDecodeData
  import ioPortDecoderPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobeT        strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] resultIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic [DATA_W-1:0] stimVec,
  output logic [MODE_W-1:0] modeBits
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stimVec  <= '0;
      modeBits <= '0;
    end else begin
      if (strobe.wrStim) stimVec  <= dataIn;
      if (strobe.wrMode) modeBits <= dataIn[MODE_W-1:0];
    end
  end

  assign dataOutEn = strobe.rdResult;
  assign dataOut   = strobe.rdResult ? resultIn : '0;
endmodule

// File: rtl/ioPortDecoder.sv
module ioPortDecoder
  import ioPortDecoderPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MODE_W = 2,
  parameter int SEL_LO = 1,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memIoN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] resultIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              resultRdN,
  output logic              stimLoadN,
  output logic              regResetN,
  output logic              regClockN,
  output logic              modeLoadN,
  output logic [DATA_W-1:0] stimVec,
  output logic [MODE_W-1:0] modeBits
);
  portStrobeT strobe;

  ioDecodeCtrl #(
    .ADDR_W(ADDR_W), .SEL_LO(SEL_LO), .SEL_W(SEL_W)
  ) u_ctrl (
    .addr(addr), .memIoN(memIoN), .rdN(rdN), .wrN(wrN), .strobe(strobe)
  );

  ioDecodeData #(
    .DATA_W(DATA_W), .MODE_W(MODE_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .resultIn(resultIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .stimVec(stimVec), .modeBits(modeBits)
  );

  assign resultRdN = !strobe.rdResult;
  assign stimLoadN = !strobe.wrStim;
  assign regResetN = !strobe.wrReset;
  assign regClockN = !strobe.wrClock;
  assign modeLoadN = !strobe.wrMode;
endmodule

// File: rtl/ioPortDecoderChk.sv
module ioPortDecoderChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              memIoN,
  input logic              rdN,
  input logic              wrN,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] resultIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn,
  input logic              resultRdN,
  input logic              stimLoadN,
  input logic              regResetN,
  input logic              regClockN,
  input logic              modeLoadN,
  input logic [DATA_W-1:0] stimVec,
  input logic [MODE_W-1:0] modeBits
);
  logic [4:0] allSelN;
  assign allSelN = {resultRdN, stimLoadN, regResetN, regClockN, modeLoadN};

  assert_memcycle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    memIoN |-> (&allSelN));
  assert_high_addr_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    addr[ADDR_W-1] |-> (&allSelN));
  assert_odd_addr_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    addr[0] |-> (&allSelN));
  assert_read_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> (!rdN && !resultRdN && dataOut == resultIn));
  assert_stim_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stimLoadN |=> (stimVec == $past(dataIn)));
  assert_stim_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    stimLoadN |=> $stable(stimVec));
  assert_strobe_needs_wr_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrN |-> (regResetN && regClockN && modeLoadN && stimLoadN));
  assert_mode_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    !modeLoadN |=> (modeBits == $past(dataIn[MODE_W-1:0])));
  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == '0));
  assert_one_write_sel_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~stimLoadN, ~regResetN, ~regClockN, ~modeLoadN}) <= 1);
endmodule

bind ioPortDecoder ioPortDecoderChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W)
) u_chk (.*);

// File: tb/ioPortDecoder_tb.sv
module ioPortDecoder_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] addr;
  logic        memIoN, rdN, wrN;
  logic [7:0]  dataIn, resultIn;
  logic [7:0]  dataOut, stimVec;
  logic        dataOutEn, resultRdN, stimLoadN, regResetN, regClockN, modeLoadN;
  logic [1:0]  modeBits;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ioPortDecoder u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .memIoN(memIoN), .rdN(rdN), .wrN(wrN),
    .dataIn(dataIn), .resultIn(resultIn), .dataOut(dataOut), .dataOutEn(dataOutEn),
    .resultRdN(resultRdN), .stimLoadN(stimLoadN), .regResetN(regResetN),
    .regClockN(regClockN), .modeLoadN(modeLoadN), .stimVec(stimVec), .modeBits(modeBits)
  );

  // Vector: {memIoN, rdN, wrN, addr[15:0], expected selects rd,stim,rst,clk,mode}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {3'b101, 16'h0000, 5'b11111},
    {3'b110, 16'h0004, 5'b11111},
    {3'b001, 16'h0000, 5'b01111},
    {3'b010, 16'h0000, 5'b10111},
    {3'b010, 16'h0002, 5'b11011},
    {3'b010, 16'h0004, 5'b11101},
    {3'b010, 16'h0006, 5'b11110},
    {3'b010, 16'h8004, 5'b11111},
    {3'b010, 16'h0003, 5'b11111},
    {3'b010, 16'h7FE4, 5'b11101},
    {3'b001, 16'h3A20, 5'b01111},
    {3'b001, 16'h0002, 5'b11111},
    {3'b010, 16'h0008, 5'b11111},
    {3'b011, 16'h0004, 5'b11111},
    {3'b010, 16'h001E, 5'b11111}
  };
  localparam logic [23:0] VREQ [NV] = '{
    "R1 ", "R1 ", "R5 ", "R6 ", "R7 ", "R7 ", "R8 ", "R2 ",
    "R3 ", "R4 ", "R4 ", "R12", "R12", "R7 ", "R12"
  };

  task automatic check(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    memIoN = 1'b0; rdN = 1'b1; wrN = 1'b1; addr = 16'h0000; dataIn = 8'h00;
  endtask

  // Write held low across one rising edge, then released
  task automatic doWrite(input logic io, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    memIoN = ~io; addr = a; dataIn = d; wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    rstN = 1'b0; resultIn = 8'h00;
    idle();
    repeat (2) @(negedge clk);
    check("R10", {22'b0, modeBits, stimVec}, 32'h0);
    check("R9 ", {23'b0, dataOutEn, dataOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: select outputs (combinational)
    for (int i = 0; i < NV; i++) begin
      memIoN = VEC[i][23]; rdN = VEC[i][22]; wrN = VEC[i][21]; addr = VEC[i][20:5];
      #1;
      check(VREQ[i], {27'b0, resultRdN, stimLoadN, regResetN, regClockN, modeLoadN},
            {27'b0, VEC[i][4:0]});
      check("R11", {31'b0, ($countones({~stimLoadN, ~regResetN, ~regClockN, ~modeLoadN}) <= 1)},
            32'h1);
      idle();
      #1;
    end

    // Read data path, R5 and R9
    @(negedge clk);
    resultIn = 8'hA5; addr = 16'h0000; rdN = 1'b0;
    #1 check("R5 ", {23'b0, dataOutEn, dataOut}, {23'b0, 1'b1, 8'hA5});
    addr = 16'h0004;
    #1 check("R9 ", {23'b0, dataOutEn, dataOut}, 32'h0);
    rdN = 1'b1; addr = 16'h0000;
    #1 check("R9 ", {23'b0, dataOutEn, dataOut}, 32'h0);
    idle();

    // Stimulus latch, R6 and R12
    doWrite(1'b1, 16'h0000, 8'h3C);
    check("R6 ", {24'b0, stimVec}, 32'h3C);
    doWrite(1'b1, 16'h0002, 8'h99);
    check("R12", {24'b0, stimVec}, 32'h3C);
    doWrite(1'b1, 16'h0001, 8'h77);
    check("R3 ", {24'b0, stimVec}, 32'h3C);
    doWrite(1'b1, 16'h5F40, 8'h81);
    check("R4 ", {24'b0, stimVec}, 32'h81);

    // Mode latch, R8 and R1
    doWrite(1'b1, 16'h0006, 8'hFE);
    check("R8 ", {30'b0, modeBits}, 32'h2);
    doWrite(1'b0, 16'h0006, 8'h55);
    check("R1 ", {30'b0, modeBits}, 32'h2);
    doWrite(1'b1, 16'h8006, 8'h01);
    check("R2 ", {30'b0, modeBits}, 32'h2);
    doWrite(1'b1, 16'h000C, 8'h03);
    check("R12", {30'b0, modeBits}, 32'h2);

    // Reset clears the latches
    @(negedge clk);
    rstN = 1'b0;
    #1 check("R10", {22'b0, modeBits, stimVec}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule